// File: doc/BRIEF.md
# ADC Histogram Linearity Analyzer

This block watches the digital output of a converter under test while a slow triangle ramp is swept across its input many times. Every valid sample bumps a hit counter for the code it carries, and all sweeps pile into the same histogram. A start pulse clears the histogram and opens acquisition. A finish pulse closes it and launches post-processing.

Post-processing walks the codes from lowest to highest. For each code it derives a signed Q4.12 differential linearity value from the ratio of that code's hits to the mean hit count. It then builds an integral linearity curve by trapezoidal summation of neighbouring differential values. In the same pass it builds a cumulative transfer characteristic from neighbouring counts. Finally it reports one RMS figure for each linearity curve.

Division is done by a shared bit-serial restoring divider, one quotient bit per cycle. The RMS figures come from a bit-serial integer square root. All results are read through a single port indexed by code, and a done flag marks them as valid.

Top module: `adc_hist_lin`

## Requirements
- R1: After reset, and in the cycle after start_i, done_o is 0 and every code's count reads 0 on rd_count_o.
- R2: While acquiring, each cycle with smp_valid_i=1 adds exactly one to the count of code smp_code_i. Cycles with smp_valid_i=0 change nothing.
- R3: A count that has reached 2^CNT_W-1 stays at that value when further hits arrive.
- R4: Samples presented before the first start, during post-processing or after done_o has risen leave every count unchanged.
- R5: With T the total of all counts and c the count of a code, rd_dle_o holds floor(c*2^(CODE_W+12)/T) - 4096 as a two's-complement Q4.12 value, limited to at most 32767. If T is 0, every entry is 0.
- R6: The integral value of code 0 is 0. For each code i>0, ILE[i] = ILE[i-1] + floor((DLE[i]+DLE[i-1])/2), limited to the signed 16-bit range.
- R7: rd_xfer_o gives the transfer characteristic in half-count units (1 fractional bit): X[0]=0 and X[i]=X[i-1]+c[i-1]+c[i].
- R8: rms_dle_o and rms_ile_o each equal floor(sqrt(floor(S/2^CODE_W))), in Q4.12, where S is the sum over all codes of the squared raw Q4.12 values of the matching curve.
- R9: done_o rises once post-processing completes after a finish_i given during acquisition, and it stays high until the next start_i. A finish_i given outside acquisition does nothing.
- R10: A start_i during post-processing abandons it, clears the counts and re-opens acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Clear histogram and begin acquisition |
| finish_i | input | 1 | End acquisition and begin post-processing |
| smp_valid_i | input | 1 | Sample strobe |
| smp_code_i | input | CODE_W | Sampled converter code |
| rd_code_i | input | CODE_W | Code selected for readout |
| rd_count_o | output | CNT_W | Hit count of the selected code |
| rd_dle_o | output | 16 | Differential linearity of the selected code, Q4.12 |
| rd_ile_o | output | 16 | Integral linearity of the selected code, Q4.12 |
| rd_xfer_o | output | CNT_W+CODE_W+1 | Transfer characteristic, half-count units |
| rms_dle_o | output | 16 | RMS of the differential curve, Q4.12 |
| rms_ile_o | output | 16 | RMS of the integral curve, Q4.12 |
| done_o | output | 1 | Results valid |

## Verification
The bench drives a code whose counter runs far past its limit. A wrapping counter would show a small count there and a strongly negative differential value instead of the clamped 32767. An empty histogram is finished so that the zero-total guard is exercised: a design lacking it would hang in the divider or give nonzero curves. Negative neighbour sums check floor rounding in the trapezoid step, where truncation toward zero would push the integral curve off by one LSB per code. Samples sent while idle, during processing and after done, finish pulses outside acquisition, and a restart in the middle of processing confirm that the histogram and the done flag only change when they should.

// File: rtl/adc_hist_pkg.sv
package adc_hist_pkg;
  localparam int Q_W   = 16;
  localparam int FRAC  = 12;
  localparam int ONE_I = 1 << FRAC;
  localparam int Q_MAXI = (1 << (Q_W - 1)) - 1;
  localparam int Q_MINI = -(1 << (Q_W - 1));

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ, ST_DIVGO, ST_DIVWAIT, ST_STORE, ST_SQGO, ST_SQWAIT, ST_DONE
  } lin_state_e;

  // clamp a wide signed value into the Q4.12 range
  function automatic logic signed [Q_W-1:0] sat_q(input logic signed [31:0] v);
    logic signed [31:0] c;
    if (v > Q_MAXI)      c = Q_MAXI;
    else if (v < Q_MINI) c = Q_MINI;
    else                 c = v;
    return c[Q_W-1:0];
  endfunction

  // ratio (count/mean in Q.12) minus one
  function automatic logic signed [Q_W-1:0] dle_from_ratio(input logic [31:0] q);
    logic signed [31:0] v;
    v = $signed(q) - ONE_I;
    return sat_q(v);
  endfunction

  // trapezoidal integration step with floor halving
  function automatic logic signed [Q_W-1:0] ile_step(input logic signed [Q_W-1:0] prev,
                                                     input logic signed [Q_W-1:0] a,
                                                     input logic signed [Q_W-1:0] b);
    logic signed [31:0] pe, ae, be, s;
    pe = prev;
    ae = a;
    be = b;
    s  = (ae + be) >>> 1;
    return sat_q(pe + s);
  endfunction

  function automatic logic [2*Q_W-1:0] sq_mag(input logic signed [Q_W-1:0] x);
    logic signed [2*Q_W-1:0] xe, p;
    xe = x;
    p  = xe * xe;
    return p;
  endfunction
endpackage

// File: rtl/adc_hist_bank.sv
module adc_hist_bank #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       hit_i,
  input  logic [CODE_W-1:0]          code_i,
  input  logic [CODE_W-1:0]          rda_code_i,
  output logic [CNT_W-1:0]           rda_cnt_o,
  input  logic [CODE_W-1:0]          rdb_code_i,
  output logic [CNT_W-1:0]           rdb_cnt_o,
  output logic [CNT_W+CODE_W-1:0]    total_o,
  output logic                       inc_o
);
  localparam int N     = 1 << CODE_W;
  localparam int TOT_W = CNT_W + CODE_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [N];
  logic [N-1:0]     inc_vec;
  logic [TOT_W-1:0] total_q;

  for (genvar g = 0; g < N; g++) begin : g_cnt
    assign inc_vec[g] = hit_i && (code_i == CODE_W'(g)) && (cnt_q[g] != CMAX);
    always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q[g] <= '0;
      else if (clr_i)      cnt_q[g] <= '0;
      else if (inc_vec[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign inc_o = |inc_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)     total_q <= '0;
    else if (clr_i) total_q <= '0;
    else if (inc_o) total_q <= total_q + 1'b1;
  end

  assign total_o   = total_q;
  assign rda_cnt_o = cnt_q[rda_code_i];
  assign rdb_cnt_o = cnt_q[rdb_code_i];
endmodule

// File: rtl/adc_hist_div.sv
module adc_hist_div #(
  parameter int NUM_W = 28,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int LC_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [LC_W-1:0]  left_q;
  logic [DEN_W:0]   trial_w;
  logic             fit_w;

  assign trial_w = {rem_q, quo_q[NUM_W-1]};
  assign fit_w   = trial_w >= {1'b0, den_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      left_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        left_q <= LC_W'(NUM_W);
      end else if (left_q != '0) begin
        if (fit_w) rem_q <= DEN_W'(trial_w - {1'b0, den_i});
        else       rem_q <= trial_w[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], fit_w};
        left_q <= left_q - 1'b1;
        if (left_q == LC_W'(1)) done_o <= 1'b1;
      end
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/adc_hist_isqrt.sv
module adc_hist_isqrt #(
  parameter int IN_W  = 32,
  parameter int OUT_W = IN_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [IN_W-1:0]  val_i,
  output logic             done_o,
  output logic [OUT_W-1:0] root_o
);
  localparam int BIT_W = $clog2(OUT_W);

  logic [IN_W-1:0]  val_q;
  logic [OUT_W-1:0] root_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q;
  logic [OUT_W-1:0] trial_w;
  logic [IN_W-1:0]  tx_w, sq_w;

  assign trial_w = root_q | (OUT_W'(1) << bit_q);
  assign tx_w    = {{(IN_W-OUT_W){1'b0}}, trial_w};
  assign sq_w    = tx_w * tx_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      root_q <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        val_q  <= val_i;
        root_q <= '0;
        bit_q  <= BIT_W'(OUT_W - 1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (sq_w <= val_q) root_q <= trial_w;
        if (bit_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          bit_q <= bit_q - 1'b1;
        end
      end
    end
  end

  assign root_o = root_q;
endmodule

// File: rtl/adc_hist_lin.sv
module adc_hist_lin
  import adc_hist_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    finish_i,
  input  logic                    smp_valid_i,
  input  logic [CODE_W-1:0]       smp_code_i,
  input  logic [CODE_W-1:0]       rd_code_i,
  output logic [CNT_W-1:0]        rd_count_o,
  output logic [15:0]             rd_dle_o,
  output logic [15:0]             rd_ile_o,
  output logic [CNT_W+CODE_W:0]   rd_xfer_o,
  output logic [15:0]             rms_dle_o,
  output logic [15:0]             rms_ile_o,
  output logic                    done_o
);
  localparam int N     = 1 << CODE_W;
  localparam int TOT_W = CNT_W + CODE_W;
  localparam int XF_W  = TOT_W + 1;
  localparam int DIV_N = CNT_W + CODE_W + FRAC;
  localparam int SQ_W  = 2 * Q_W;
  localparam int ACC_W = SQ_W + CODE_W;

  lin_state_e st_q;
  logic [CODE_W-1:0] idx_q;
  logic [DIV_N-1:0]  q_r;

  // named internal events, used by the checker
  logic              acq_w, inc_w, store_w, div_go_w, sq_go_w;
  logic [TOT_W-1:0]  total_w;

  logic [CNT_W-1:0]  cur_cnt_w;
  logic              div_done_w;
  logic [DIV_N-1:0]  div_quo_w;

  logic signed [Q_W-1:0] prev_dle_q, prev_ile_q;
  logic [XF_W-1:0]       prev_xfer_q;
  logic [CNT_W-1:0]      prev_cnt_q;
  logic [ACC_W-1:0]      acc_dle_q, acc_ile_q;

  logic [Q_W-1:0]  dle_q  [N];
  logic [Q_W-1:0]  ile_q  [N];
  logic [XF_W-1:0] xfer_q [N];
  logic [Q_W-1:0]  rms_dle_q, rms_ile_q;

  logic signed [Q_W-1:0] dle_w, ile_w;
  logic [XF_W-1:0]       xfer_w;

  assign acq_w    = (st_q == ST_ACQ);
  assign store_w  = (st_q == ST_STORE);
  assign div_go_w = (st_q == ST_DIVGO) && (total_w != '0);
  assign sq_go_w  = (st_q == ST_SQGO);

  adc_hist_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_i),
    .hit_i      (smp_valid_i && acq_w),
    .code_i     (smp_code_i),
    .rda_code_i (rd_code_i),
    .rda_cnt_o  (rd_count_o),
    .rdb_code_i (idx_q),
    .rdb_cnt_o  (cur_cnt_w),
    .total_o    (total_w),
    .inc_o      (inc_w)
  );

  adc_hist_div #(.NUM_W(DIV_N), .DEN_W(TOT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_go_w),
    .num_i  ({cur_cnt_w, {(CODE_W+FRAC){1'b0}}}),
    .den_i  (total_w),
    .done_o (div_done_w),
    .quo_o  (div_quo_w)
  );

  // two identical root extractors, one per curve
  logic [SQ_W-1:0] sq_in_w   [2];
  logic            sq_done_w [2];
  logic [Q_W-1:0]  sq_root_w [2];

  assign sq_in_w[0] = acc_dle_q[CODE_W +: SQ_W];
  assign sq_in_w[1] = acc_ile_q[CODE_W +: SQ_W];

  for (genvar k = 0; k < 2; k++) begin : g_sqrt
    adc_hist_isqrt #(.IN_W(SQ_W), .OUT_W(Q_W)) u_sqrt (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (sq_go_w),
      .val_i  (sq_in_w[k]),
      .done_o (sq_done_w[k]),
      .root_o (sq_root_w[k])
    );
  end

  assign dle_w  = dle_from_ratio(32'(q_r));
  assign ile_w  = (idx_q == '0) ? '0 : ile_step(prev_ile_q, dle_w, prev_dle_q);
  assign xfer_w = (idx_q == '0) ? '0
                : prev_xfer_q + XF_W'(prev_cnt_q) + XF_W'(cur_cnt_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      q_r         <= '0;
      prev_dle_q  <= '0;
      prev_ile_q  <= '0;
      prev_xfer_q <= '0;
      prev_cnt_q  <= '0;
      acc_dle_q   <= '0;
      acc_ile_q   <= '0;
      rms_dle_q   <= '0;
      rms_ile_q   <= '0;
    end else if (start_i) begin
      st_q <= ST_ACQ;
    end else begin
      unique case (st_q)
        ST_IDLE: st_q <= ST_IDLE;
        ST_ACQ: if (finish_i) begin
          st_q      <= ST_DIVGO;
          idx_q     <= '0;
          acc_dle_q <= '0;
          acc_ile_q <= '0;
        end
        ST_DIVGO: begin
          if (total_w == '0) begin
            q_r  <= DIV_N'(ONE_I);
            st_q <= ST_STORE;
          end else begin
            st_q <= ST_DIVWAIT;
          end
        end
        ST_DIVWAIT: if (div_done_w) begin
          q_r  <= div_quo_w;
          st_q <= ST_STORE;
        end
        ST_STORE: begin
          prev_dle_q  <= dle_w;
          prev_ile_q  <= ile_w;
          prev_xfer_q <= xfer_w;
          prev_cnt_q  <= cur_cnt_w;
          acc_dle_q   <= acc_dle_q + ACC_W'(sq_mag(dle_w));
          acc_ile_q   <= acc_ile_q + ACC_W'(sq_mag(ile_w));
          if (idx_q == CODE_W'(N - 1)) st_q <= ST_SQGO;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_DIVGO;
          end
        end
        ST_SQGO: st_q <= ST_SQWAIT;
        ST_SQWAIT: if (sq_done_w[0]) begin
          rms_dle_q <= sq_root_w[0];
          rms_ile_q <= sq_root_w[1];
          st_q      <= ST_DONE;
        end
        ST_DONE: st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        dle_q[i]  <= '0;
        ile_q[i]  <= '0;
        xfer_q[i] <= '0;
      end
    end else if (store_w && !start_i) begin
      dle_q[idx_q]  <= dle_w;
      ile_q[idx_q]  <= ile_w;
      xfer_q[idx_q] <= xfer_w;
    end
  end

  assign rd_dle_o  = dle_q[rd_code_i];
  assign rd_ile_o  = ile_q[rd_code_i];
  assign rd_xfer_o = xfer_q[rd_code_i];
  assign rms_dle_o = rms_dle_q;
  assign rms_ile_o = rms_ile_q;
  assign done_o    = (st_q == ST_DONE);
endmodule

// File: rtl/adc_hist_lin_chk.sv
module adc_hist_lin_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic [CODE_W-1:0]       rd_code_i,
  input logic [CNT_W-1:0]        rd_count_o,
  input logic [15:0]             rd_dle_o,
  input logic [15:0]             rd_ile_o,
  input logic [CNT_W+CODE_W:0]   rd_xfer_o,
  input logic                    done_o,
  input logic                    acq_w,
  input logic                    inc_w,
  input logic [CNT_W+CODE_W-1:0] total_w
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && total_w == '0));

  p_inc_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_w && !start_i) |=> (total_w == $past(total_w) + 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count_o == CMAX && !start_i) |=>
      (rd_count_o == CMAX || rd_code_i != $past(rd_code_i)));

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_w |-> !inc_w);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_w && !start_i) |=> $stable(total_w));

  p_dle_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($signed(rd_dle_o) >= -16'sd4096));

  p_base_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rd_code_i == '0) |-> (rd_ile_o == '0 && rd_xfer_o == '0)); // R7 too

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> acq_w);
endmodule

bind adc_hist_lin adc_hist_lin_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rd_code_i  (rd_code_i),
  .rd_count_o (rd_count_o),
  .rd_dle_o   (rd_dle_o),
  .rd_ile_o   (rd_ile_o),
  .rd_xfer_o  (rd_xfer_o),
  .done_o     (done_o),
  .acq_w      (acq_w),
  .inc_w      (inc_w),
  .total_w    (total_w)
);

// File: tb/tb_adc_hist_lin.sv
module tb_adc_hist_lin;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 12;
  localparam int N      = 1 << CODE_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, finish_i = 1'b0, smp_valid_i = 1'b0;
  logic [CODE_W-1:0] smp_code_i = '0, rd_code_i = '0;
  logic [CNT_W-1:0] rd_count_o;
  logic [15:0] rd_dle_o, rd_ile_o, rms_dle_o, rms_ile_o;
  logic [CNT_W+CODE_W:0] rd_xfer_o;
  logic done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_hist_lin #(.CODE_W(CODE_W), .CNT_W(CNT_W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  int exp_cnt [N];
  bit in_acq = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_dle(input int c, input int tot);
    longint v;
    if (tot == 0) return 0;
    v = ((longint'(c) * 65536) / tot) - 4096;
    return (v > 32767) ? 32767 : v;
  endfunction

  function automatic longint half_floor(input longint s);
    if (s >= 0) return s / 2;
    return -((-s + 1) / 2);
  endfunction

  function automatic longint ref_root(input longint m);
    longint lo = 0, hi = 65535;
    while (lo < hi) begin
      longint mid = (lo + hi + 1) / 2;
      if (mid * mid <= m) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  task automatic send(input int code, input bit v);
    @(negedge clk);
    smp_valid_i = v;
    smp_code_i  = CODE_W'(code);
    if (v && in_acq && exp_cnt[code] < CMAX) exp_cnt[code]++;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    smp_valid_i = 0; start_i = 1; in_acq = 1;
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic pulse_finish();
    @(negedge clk);
    smp_valid_i = 0; finish_i = 1; in_acq = 0;
    @(negedge clk);
    finish_i = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk("R9", {tag, " done rises"}, longint'(done_o), 1);
  endtask

  task automatic check_counts(input string req, input string tag);
    for (int c = 0; c < N; c++) begin
      @(negedge clk); rd_code_i = CODE_W'(c); #1;
      chk(req, $sformatf("%s count[%0d]", tag, c), longint'(rd_count_o), exp_cnt[c]);
    end
  endtask

  task automatic check_results(input string tag);
    int tot = 0;
    longint d [N], il [N], x [N];
    longint sd = 0, si = 0;
    foreach (exp_cnt[i]) tot += exp_cnt[i];
    for (int i = 0; i < N; i++) begin
      d[i] = ref_dle(exp_cnt[i], tot);
      if (i == 0) begin il[i] = 0; x[i] = 0; end
      else begin
        il[i] = il[i-1] + half_floor(d[i] + d[i-1]);
        if (il[i] > 32767) il[i] = 32767;
        if (il[i] < -32768) il[i] = -32768;
        x[i] = x[i-1] + exp_cnt[i-1] + exp_cnt[i];
      end
      sd += d[i] * d[i];
      si += il[i] * il[i];
    end
    for (int c = 0; c < N; c++) begin
      @(negedge clk); rd_code_i = CODE_W'(c); #1;
      chk("R2", $sformatf("%s count[%0d]", tag, c), longint'(rd_count_o), exp_cnt[c]);
      chk("R5", $sformatf("%s dle[%0d]", tag, c), longint'($signed(rd_dle_o)), d[c]);
      chk("R6", $sformatf("%s ile[%0d]", tag, c), longint'($signed(rd_ile_o)), il[c]);
      chk("R7", $sformatf("%s xfer[%0d]", tag, c), longint'(rd_xfer_o), x[c]);
    end
    chk("R8", {tag, " rms dle"}, longint'(rms_dle_o), ref_root(sd / N));
    chk("R8", {tag, " rms ile"}, longint'(rms_ile_o), ref_root(si / N));
  endtask

  task automatic finish_run(input string tag);
    pulse_finish();
    for (int k = 0; k < 8; k++) send(k, 1'b1);   // R4: during processing
    @(negedge clk); smp_valid_i = 0;
    wait_done(tag);
    check_results(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "done after reset", longint'(done_o), 0);
    check_counts("R1", "reset");
    // R4 / R9: idle samples and finish are ignored
    for (int k = 0; k < 6; k++) send(k, 1'b1);
    pulse_finish();
    repeat (40) @(negedge clk);
    chk("R9", "idle finish ignored", longint'(done_o), 0);
    check_counts("R4", "idle samples");

    // directed triangle sweeps with code-dependent dwell
    pulse_start();
    chk("R1", "done after start", longint'(done_o), 0);
    for (int p = 0; p < 120; p++) begin
      for (int c = 0; c < N; c++) for (int r = 0; r <= c % 3; r++) send(c, 1'b1);
      for (int c = N - 1; c >= 0; c--) send(c, (c % 5) != 0);
    end
    @(negedge clk); smp_valid_i = 0;
    check_counts("R2", "triangle mid-acq");
    finish_run("triangle");
    // R9: finish after done ignored, R4 samples after done ignored
    pulse_finish();
    for (int k = 0; k < 10; k++) send(k, 1'b1);
    @(negedge clk); smp_valid_i = 0;
    repeat (10) @(negedge clk);
    chk("R9", "done holds", longint'(done_o), 1);
    check_counts("R4", "post-done samples");

    // constrained random, skewed towards low codes
    pulse_start();
    for (int k = 0; k < 900; k++) begin
      int c = ($urandom % 3 == 0) ? int'($urandom % 4) : int'($urandom % N);
      send(c, ($urandom % 4) != 0);
    end
    finish_run("random");

    // saturation and DLE clamp
    pulse_start();
    for (int k = 0; k < 4300; k++) send(7, 1'b1);
    for (int k = 0; k < 5; k++) send(k, 1'b1);
    @(negedge clk); smp_valid_i = 0;
    @(negedge clk); rd_code_i = 7; #1;
    chk("R3", "saturated count", longint'(rd_count_o), CMAX);
    finish_run("saturate");
    rd_code_i = 7; #1;
    chk("R5", "clamped dle", longint'($signed(rd_dle_o)), 32767);

    // empty histogram
    pulse_start();
    finish_run("empty");

    // R10: restart in the middle of processing
    pulse_start();
    for (int k = 0; k < 40; k++) send(k % N, 1'b1);
    pulse_finish();
    repeat (60) @(negedge clk);
    pulse_start();
    chk("R10", "done after restart", longint'(done_o), 0);
    check_counts("R10", "restart clear");
    for (int k = 0; k < 200; k++) send(int'($urandom % N), 1'b1);
    finish_run("restart");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule